// File: doc/BRIEF.md
# Address-Routed Serial Register Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a latch enable. All three wires are brought into the system clock domain through synchronizer chains. Each rising edge of the serial clock shifts one bit into an 18-bit shift register, most significant bit first. The lowest bit of the word is a routing bit. The 17 bits above it are the payload.

When a rising edge of latch enable is seen, the word is copied into one of two control registers. A routing bit of 1 selects the reference register and a routing bit of 0 selects the divide register. The other register keeps its contents. Both registers are decoded into named fields that drive the rest of the synthesizer. The interface has no power-down gating, so words can still be loaded while the power-down field requests power-down.

A small controller detects the latch edge. It has three states:
- `ST_HOLD`: latch enable is high, or the block has just come out of reset. It moves to `ST_IDLE` once latch enable is low.
- `ST_IDLE`: the controller waits for latch enable. It moves to `ST_LOAD` when latch enable goes high.
- `ST_LOAD`: a single cycle that issues the commit strobe. It always moves to `ST_HOLD`.

Because reset enters `ST_HOLD`, a latch enable that is already high when reset ends does not cause a load.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset every output field is zero. A power-down field of 0 means normal operation.
- R2: Bits are shifted in most significant bit first. The first bit of an 18-bit frame ends in word bit 17 and the last bit ends in word bit 0, the routing bit.
- R3: With routing bit 1, the reference register loads word bits 17..1 as follows: option = bits 17..15, charge-pump tri-state = bit 14, lock-detect select = bits 13..12, detector polarity = bit 11, reference count = bits 10..1.
- R4: With routing bit 0, the divide register loads word bits 17..1 as follows: power-down mode = bits 17..16, B count = bits 15..6, A count = bits 5..1.
- R5: A load changes only the register selected by the routing bit. The other register keeps its value.
- R6: Shifting bits while latch enable stays low changes no output.
- R7: If more than 18 bits are shifted before the latch, only the last 18 are kept.
- R8: One latch pulse gives exactly one load. Bits shifted while latch enable is held high are not loaded until the next rising edge of latch enable.
- R9: A load is accepted whatever value the power-down field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_latch | input | 1 | Latch enable; its rising edge commits the word |
| ref_count | output | 10 | Reference divider count |
| pfd_pol | output | 1 | Phase detector polarity |
| lock_sel | output | 2 | Lock-detect output select |
| r_option | output | 3 | Reference register option field |
| cp_tristate | output | 1 | Charge-pump tri-state request |
| a_count | output | 5 | A counter value |
| b_count | output | 10 | B counter value |
| pwrdn_mode | output | 2 | Power-down control word |

## Verification
The assertions check every cycle that outputs move only in the cycle after a commit strobe, and never two cycles in a row. They also check that a commit copies the payload into the register named by the routing bit and leaves the other register untouched. The bench scenarios are what show that the bit order and the synchronizer path are right, that over-long frames are truncated, that holding the latch high defers a load to the next pulse, and that the reset values are correct.

// File: rtl/serload_pkg.sv
package serload_pkg;
    localparam int WORD_W = 18;
    localparam int DATA_W = WORD_W - 1;
    localparam int REF_W  = 10;
    localparam int LCK_W  = 2;
    localparam int OPT_W  = 3;
    localparam int A_W    = 5;
    localparam int B_W    = 10;
    localparam int PD_W   = 2;

    typedef struct packed {
        logic [OPT_W-1:0] opt;
        logic             cp_tri;
        logic [LCK_W-1:0] lock_sel;
        logic             pfd_pol;
        logic [REF_W-1:0] ref_cnt;
    } rreg_t;

    typedef struct packed {
        logic [PD_W-1:0] pd;
        logic [B_W-1:0]  b_cnt;
        logic [A_W-1:0]  a_cnt;
    } nreg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } ld_state_e;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int N_BITS = 3,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] d_async,
    output logic [N_BITS-1:0] d_sync
);
    logic [N_BITS-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[g] <= '0;
                else if (g == 0)
                    chain[g] <= d_async;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/sl_shift.sv
module sl_shift #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic [WORD_W-1:0] word
);
    logic sclk_q;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            word   <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (sclk_rise)
                word <= {word[WORD_W-2:0], sdat_s};
        end
    end
endmodule

// File: rtl/sl_ctrl.sv
module sl_ctrl
    import serload_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_s,
    output logic commit
);
    ld_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HOLD;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (le_s)  state_nx = ST_LOAD;
            ST_LOAD:            state_nx = ST_HOLD;
            ST_HOLD: if (!le_s) state_nx = ST_IDLE;
            default:            state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            ST_LOAD: commit = 1'b1;
            default: commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import serload_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_latch,
    output logic [REF_W-1:0] ref_count,
    output logic             pfd_pol,
    output logic [LCK_W-1:0] lock_sel,
    output logic [OPT_W-1:0] r_option,
    output logic             cp_tristate,
    output logic [A_W-1:0]   a_count,
    output logic [B_W-1:0]   b_count,
    output logic [PD_W-1:0]  pwrdn_mode
);
    logic [2:0]        wires_s;
    logic [WORD_W-1:0] shift_word;
    logic              commit;
    rreg_t             r_q;
    nreg_t             n_q;

    sl_sync #(.N_BITS(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_latch, ser_data, ser_clk}),
        .d_sync  (wires_s)
    );

    sl_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (wires_s[0]),
        .sdat_s (wires_s[1]),
        .word   (shift_word)
    );

    sl_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .le_s   (wires_s[2]),
        .commit (commit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            n_q <= '0;
        end else if (commit) begin
            if (shift_word[0])
                r_q <= rreg_t'(shift_word[WORD_W-1:1]);
            else
                n_q <= nreg_t'(shift_word[WORD_W-1:1]);
        end
    end

    assign ref_count   = r_q.ref_cnt;
    assign pfd_pol     = r_q.pfd_pol;
    assign lock_sel    = r_q.lock_sel;
    assign r_option    = r_q.opt;
    assign cp_tristate = r_q.cp_tri;
    assign a_count     = n_q.a_cnt;
    assign b_count     = n_q.b_cnt;
    assign pwrdn_mode  = n_q.pd;
endmodule

// File: rtl/serial_reg_loader_chk.sv
module serial_reg_loader_chk
    import serload_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic [WORD_W-1:0] word,
    input logic [DATA_W-1:0] r_flat,
    input logic [DATA_W-1:0] n_flat
);
    // R3
    r_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && word[0] |=> r_flat == $past(word[WORD_W-1:1]));

    // R4
    n_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !word[0] |=> n_flat == $past(word[WORD_W-1:1]));

    // R5
    n_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && word[0] |=> $stable(n_flat));

    // R5
    r_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !word[0] |=> $stable(r_flat));

    // R6
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(r_flat) && $stable(n_flat));

    // R8
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

bind serial_reg_loader serial_reg_loader_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .word   (shift_word),
    .r_flat (r_q),
    .n_flat (n_q)
);

// File: tb/serial_reg_loader_test.sv
`timescale 1ns/1ps
module serial_reg_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
    logic [9:0] ref_count;
    logic       pfd_pol;
    logic [1:0] lock_sel;
    logic [2:0] r_option;
    logic       cp_tristate;
    logic [4:0] a_count;
    logic [9:0] b_count;
    logic [1:0] pwrdn_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [16:0] exp_r = '0;
    logic [16:0] exp_n = '0;

    always #10 clk = ~clk;

    serial_reg_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .ref_count(ref_count), .pfd_pol(pfd_pol),
        .lock_sel(lock_sel), .r_option(r_option), .cp_tristate(cp_tristate),
        .a_count(a_count), .b_count(b_count), .pwrdn_mode(pwrdn_mode)
    );

    // Payload layouts from R3 and R4
    function automatic logic [16:0] act_r();
        return {r_option, cp_tristate, lock_sel, pfd_pol, ref_count};
    endfunction
    function automatic logic [16:0] act_n();
        return {pwrdn_mode, b_count, a_count};
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_latch();
        ser_latch = 1'b1;
        repeat (6) @(negedge clk);
        ser_latch = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic model_load(input logic [17:0] w);
        if (w[0]) exp_r = w[17:1];
        else      exp_n = w[17:1];
    endtask

    localparam int NVEC = 6;
    localparam logic [17:0] VEC [NVEC] = '{
        18'b101_0_10_1_1000000001_1,   // R2 R3: distinct end bits
        18'b11_0000000001_10001_0,     // R2 R4
        18'b010_1_01_0_0110011001_1,   // R3 second pattern
        18'b01_1111100000_01010_0,     // R4 pd=1 (power-down)
        18'b000_0_00_0_0000001111_1,   // R9 load while power-down requested
        18'b10_0101010101_11111_0      // R4 pd=2
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ref reg reset", act_r(), 17'h0);
        check("R1 div reg reset", act_n(), 17'h0);

        for (int v = 0; v < NVEC; v++) begin
            send_bits({14'h0, VEC[v]}, 18);
            pulse_latch();
            model_load(VEC[v]);
            check(VEC[v][0] ? "R3 R5 ref reg load" : "R4 R5 div reg load",
                  VEC[v][0] ? act_r() : act_n(), VEC[v][0] ? exp_r : exp_n);
            check("R5 R9 other reg kept",
                  VEC[v][0] ? act_n() : act_r(), VEC[v][0] ? exp_n : exp_r);
        end

        // R6: shift a full frame with no latch
        send_bits({14'h0, 18'h2AAAB}, 18);
        repeat (6) @(negedge clk);
        check("R6 ref reg unchanged w/o latch", act_r(), exp_r);
        check("R6 div reg unchanged w/o latch", act_n(), exp_n);
        pulse_latch();
        model_load(18'h2AAAB);
        check("R6 latched after pulse", act_r(), exp_r);

        // R7: 22 bits, leading 4 are dropped
        send_bits({10'h0, 4'hF, 18'h15552}, 22);
        pulse_latch();
        model_load(18'h15552);
        check("R7 div reg last 18 bits", act_n(), exp_n);
        check("R7 ref reg kept", act_r(), exp_r);

        // R8: shift while latch held high, no load until next edge
        ser_latch = 1'b1;
        repeat (6) @(negedge clk);
        send_bits({14'h0, 18'h0F0F1}, 18);
        repeat (6) @(negedge clk);
        check("R8 no load while latch held", act_r(), exp_r);
        ser_latch = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 no load on latch fall", act_r(), exp_r);
        pulse_latch();
        model_load(18'h0F0F1);
        check("R8 load on next rise", act_r(), exp_r);

        // R1: reset clears again after loads
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 ref reg re-reset", act_r(), 17'h0);
        check("R1 div reg re-reset", act_n(), 17'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule